// File: doc/BRIEF.md
# Serial Byte FIFO Pair with Fill-Level Interrupts

This block holds the receive and transmit byte queues of a serial port. The queues sit between the line side and the application. The receive queue is filled by the deserializer and drained by software. The transmit queue is filled by software and drained by the serializer. Each queue has a control byte that sets three things: a 2-bit fill-level threshold code, a trigger-mode bit, and a self-clearing flush bit. Each queue drives a one-cycle interrupt pulse when its fill level meets the selected rule. Count, full, empty and sticky overrun flags are visible at all times.

A duplex input reshapes the block. When it is high, the receive queue holds only half the base depth, and the upper bit of both threshold codes is ignored. Push and pop are single-cycle strobes. Read data is show-ahead: the byte at the head of a queue is always on its data output, and the output is zero when the queue is empty.

Threshold evaluation is built around a three-way fill region: BELOW, AT or ABOVE the threshold. It compares the region before a clock edge with the region after it. A receive "reach" is the move BELOW→AT. A transmit "reach" is the move ABOVE→AT. In trigger mode 1, two more moves raise a pulse. A receive pop that ends in ABOVE raises one, and so does a transmit push that ends in BELOW.

Top module: `sfifo_irq_ctrl`

## Requirements
- R1: After reset, both counts are 0, both empty flags are 1, the full, overrun and interrupt outputs are 0, and both control readbacks are 0x00.
- R2: Receive threshold code, half duplex: 0 selects 4 bytes, and 1, 2 and 3 select that many bytes. A push that moves the receive count from below the threshold onto it makes `rx_irq_o` high for the cycle after that edge.
- R3: Transmit threshold code: 0 selects empty (0 bytes), and 1, 2 and 3 select that many bytes. A pop that moves the transmit count from above the threshold down onto it makes `tx_irq_o` high for the cycle after that edge.
- R4: While `duplex_i` is 1, the receive queue holds 2 bytes. Receive code 0 then means 2 bytes. Bit 1 of both threshold codes is ignored, so receive code 2 acts as 2 bytes and transmit code 2 acts as empty.
- R5: With receive mode bit 1, a receive pop that leaves the count above the threshold also raises `rx_irq_o`.
- R6: With transmit mode bit 1, a transmit push that leaves the count below the threshold also raises `tx_irq_o`.
- R7: Control byte layout, for a write and for the readback: bit 7 is the flush bit, bit 6 is the mode bit, and bits 1:0 are the threshold code. Every write stores bits 6 and 1:0. The readback shows bits 7 and 5:2 as 0.
- R8: Writing a control byte with bit 7 set empties that queue and clears its overrun flag. It takes priority over a push or pop in the same cycle and raises no interrupt.
- R9: A push into a full queue without a pop in the same cycle is dropped, and it sets that queue's overrun flag. The flag holds until the queue is flushed.
- R10: Bytes leave in arrival order. A pop on an empty queue leaves the count at 0, and the data output reads 0 while the queue is empty.
- R11: An interrupt is a single-cycle pulse. A count that stays on the threshold raises no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duplex_i | input | 1 | 1 = full-duplex depth and threshold decoding |
| ctl_wr_rx_i | input | 1 | Write strobe, receive control byte |
| ctl_wr_tx_i | input | 1 | Write strobe, transmit control byte |
| ctl_wdata_i | input | 8 | Control write data |
| ctl_rx_o | output | 8 | Receive control readback |
| ctl_tx_o | output | 8 | Transmit control readback |
| rx_push_i | input | 1 | Receive push strobe (line side) |
| rx_din_i | input | 8 | Receive push data |
| rx_pop_i | input | 1 | Receive pop strobe (application) |
| rx_dout_o | output | 8 | Receive head byte, 0 when empty |
| tx_push_i | input | 1 | Transmit push strobe (application) |
| tx_din_i | input | 8 | Transmit push data |
| tx_pop_i | input | 1 | Transmit pop strobe (line side) |
| tx_dout_o | output | 8 | Transmit head byte, 0 when empty |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_count_o | output | 3 | Receive fill count |
| rx_ovr_o | output | 1 | Receive overrun, sticky |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_count_o | output | 3 | Transmit fill count |
| tx_ovr_o | output | 1 | Transmit overrun, sticky |

## Verification
The bench walks each queue across its threshold in both directions and checks the pulse count at every step.

- **Level-triggered pulse:** a design that raised the interrupt as a level would fire again on idle cycles.
- **Wrong direction:** a design that ignored the direction of approach would pulse on a receive pop onto the threshold.
- **Code 0 decode:** a design that mixed up the two meanings of code 0 would pulse on the wrong byte.
- **Duplex mode:** the bench checks that the receive queue stops at 2 bytes and that the upper code bit is masked.
- **Flush:** the bench issues a flush in the same cycle as a push. A design that lost the priority would keep a byte or pulse.
- **Empty reads and overflow:** the bench pops an empty queue and pushes a full one. A design that wrapped its pointers would return stale data or corrupt the count.

// File: rtl/sfifo_irq_pkg.sv
package sfifo_irq_pkg;

    // control byte field positions (the decoder in sfifo_ctl depends on these)
    localparam int CTL_FLUSH_BIT = 7;
    localparam int CTL_MODE_BIT  = 6;
    localparam int CODE_W        = 2;

    // position of the fill count relative to the decoded threshold
    typedef enum logic [1:0] {
        RGN_BELOW = 2'd0,
        RGN_AT    = 2'd1,
        RGN_ABOVE = 2'd2
    } fill_rgn_e;

    typedef struct packed {
        logic              mode;
        logic [CODE_W-1:0] code;
    } ctl_fields_t;

endpackage

// File: rtl/sfifo_ctl.sv
module sfifo_ctl
    import sfifo_irq_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    output ctl_fields_t      fields_o,
    output logic             flush_o,
    output logic [CTL_W-1:0] rdata_o
);

    ctl_fields_t fields_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (wr_i) begin
            fields_q.mode <= wdata_i[CTL_MODE_BIT];
            fields_q.code <= wdata_i[CODE_W-1:0];
        end
    end

    // the flush bit acts as a strobe, it is never stored
    assign flush_o  = wr_i & wdata_i[CTL_FLUSH_BIT];
    assign fields_o = fields_q;

    always_comb begin
        rdata_o                  = '0;
        rdata_o[CTL_MODE_BIT]    = fields_q.mode;
        rdata_o[CODE_W-1:0]      = fields_q.code;
    end

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^wdata_i;

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] din_i,
    input  logic [CW-1:0] lim_i,
    output logic [DW-1:0] dout_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt_o,
    output logic          push_ok_o,
    output logic          pop_ok_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          ovr_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          ovr_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty_o   = (cnt_q == '0);
    assign full_o    = (cnt_q >= lim_i);
    assign pop_ok_o  = pop_i & ~empty_o & ~flush_i;
    assign push_ok_o = push_i & ~flush_i & (~full_o | pop_ok_o);

    always_comb begin
        if (flush_i) begin
            cnt_nxt_o = '0;
        end else begin
            cnt_nxt_o = cnt_q;
            if (push_ok_o && !pop_ok_o) cnt_nxt_o = cnt_q + 1'b1;
            if (pop_ok_o && !push_ok_o) cnt_nxt_o = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            ovr_q    <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt_o;
            if (flush_i) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
                ovr_q    <= 1'b0;
            end else begin
                if (push_ok_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
                if (pop_ok_o)  rd_ptr_q <= ptr_inc(rd_ptr_q);
                if (push_i && !push_ok_o) ovr_q <= 1'b1;
            end
        end
    end

    // one write port per entry, selected by the write pointer
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_ok_o && wr_ptr_q == PW'(e)) mem_q[e] <= din_i;
        end
    end

    assign dout_o = empty_o ? '0 : mem_q[rd_ptr_q];
    assign cnt_o  = cnt_q;
    assign ovr_o  = ovr_q;

endmodule

// File: rtl/sfifo_trig.sv
module sfifo_trig
    import sfifo_irq_pkg::*;
#(
    parameter bit IS_RX = 1'b1,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duplex_i,
    input  ctl_fields_t       ctl_i,
    input  logic              flush_i,
    input  logic              push_ok_i,
    input  logic              pop_ok_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic [CW-1:0]     cnt_nxt_i,
    output logic              irq_o
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);

    logic [CODE_W-1:0] eff_code;
    logic [CW-1:0]     thr;
    fill_rgn_e         rgn_now, rgn_nxt;
    logic              reach, extra, irq_q;

    function automatic fill_rgn_e classify(input logic [CW-1:0] c, input logic [CW-1:0] t);
        if (c < t)       return RGN_BELOW;
        else if (c == t) return RGN_AT;
        else             return RGN_ABOVE;
    endfunction

    always_comb begin
        eff_code = duplex_i ? {1'b0, ctl_i.code[0]} : ctl_i.code;
        unique case (eff_code)
            2'd0:    thr = IS_RX ? (duplex_i ? HALF_LVL : FULL_LVL) : '0;
            2'd1:    thr = CW'(1);
            2'd2:    thr = CW'(2);
            default: thr = CW'(3);
        endcase
        rgn_now = classify(cnt_i, thr);
        rgn_nxt = classify(cnt_nxt_i, thr);
    end

    if (IS_RX) begin : g_rx_rule
        assign reach = (rgn_now == RGN_BELOW) && (rgn_nxt == RGN_AT);
        assign extra = ctl_i.mode && pop_ok_i && (rgn_nxt == RGN_ABOVE);
    end else begin : g_tx_rule
        assign reach = (rgn_now == RGN_ABOVE) && (rgn_nxt == RGN_AT);
        assign extra = ctl_i.mode && push_ok_i && (rgn_nxt == RGN_BELOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ~flush_i & (reach | extra);
    end

    assign irq_o = irq_q;

    logic unused_trig_in;
    assign unused_trig_in = push_ok_i ^ pop_ok_i;

endmodule

// File: rtl/sfifo_irq_ctrl.sv
module sfifo_irq_ctrl
    import sfifo_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int CTL_W  = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duplex_i,
    input  logic              ctl_wr_rx_i,
    input  logic              ctl_wr_tx_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    output logic [CTL_W-1:0]  ctl_rx_o,
    output logic [CTL_W-1:0]  ctl_tx_o,
    input  logic              rx_push_i,
    input  logic [DATA_W-1:0] rx_din_i,
    input  logic              rx_pop_i,
    output logic [DATA_W-1:0] rx_dout_o,
    input  logic              tx_push_i,
    input  logic [DATA_W-1:0] tx_din_i,
    input  logic              tx_pop_i,
    output logic [DATA_W-1:0] tx_dout_o,
    output logic              rx_irq_o,
    output logic              tx_irq_o,
    output logic              rx_full_o,
    output logic              rx_empty_o,
    output logic [CNT_W-1:0]  rx_count_o,
    output logic              rx_ovr_o,
    output logic              tx_full_o,
    output logic              tx_empty_o,
    output logic [CNT_W-1:0]  tx_count_o,
    output logic              tx_ovr_o
);

    localparam logic [CNT_W-1:0] LIM_BASE = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(DEPTH / 2);

    ctl_fields_t      rx_ctl, tx_ctl;
    logic             rx_flush, tx_flush;
    logic [CNT_W-1:0] rx_lim, rx_nxt, tx_nxt;
    logic             rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;

    assign rx_lim = duplex_i ? LIM_HALF : LIM_BASE;

    sfifo_ctl #(.CTL_W(CTL_W)) u_rx_ctl (
        .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_rx_i), .wdata_i(ctl_wdata_i),
        .fields_o(rx_ctl), .flush_o(rx_flush), .rdata_o(ctl_rx_o)
    );

    sfifo_ctl #(.CTL_W(CTL_W)) u_tx_ctl (
        .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_tx_i), .wdata_i(ctl_wdata_i),
        .fields_o(tx_ctl), .flush_o(tx_flush), .rdata_o(ctl_tx_o)
    );

    sfifo_store #(.DW(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_rx_store (
        .clk(clk), .rst_n(rst_n), .flush_i(rx_flush), .push_i(rx_push_i),
        .pop_i(rx_pop_i), .din_i(rx_din_i), .lim_i(rx_lim), .dout_o(rx_dout_o),
        .cnt_o(rx_count_o), .cnt_nxt_o(rx_nxt), .push_ok_o(rx_push_ok),
        .pop_ok_o(rx_pop_ok), .full_o(rx_full_o), .empty_o(rx_empty_o),
        .ovr_o(rx_ovr_o)
    );

    sfifo_store #(.DW(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_tx_store (
        .clk(clk), .rst_n(rst_n), .flush_i(tx_flush), .push_i(tx_push_i),
        .pop_i(tx_pop_i), .din_i(tx_din_i), .lim_i(LIM_BASE), .dout_o(tx_dout_o),
        .cnt_o(tx_count_o), .cnt_nxt_o(tx_nxt), .push_ok_o(tx_push_ok),
        .pop_ok_o(tx_pop_ok), .full_o(tx_full_o), .empty_o(tx_empty_o),
        .ovr_o(tx_ovr_o)
    );

    sfifo_trig #(.IS_RX(1'b1), .DEPTH(DEPTH), .CW(CNT_W)) u_rx_trig (
        .clk(clk), .rst_n(rst_n), .duplex_i(duplex_i), .ctl_i(rx_ctl),
        .flush_i(rx_flush), .push_ok_i(rx_push_ok), .pop_ok_i(rx_pop_ok),
        .cnt_i(rx_count_o), .cnt_nxt_i(rx_nxt), .irq_o(rx_irq_o)
    );

    sfifo_trig #(.IS_RX(1'b0), .DEPTH(DEPTH), .CW(CNT_W)) u_tx_trig (
        .clk(clk), .rst_n(rst_n), .duplex_i(duplex_i), .ctl_i(tx_ctl),
        .flush_i(tx_flush), .push_ok_i(tx_push_ok), .pop_ok_i(tx_pop_ok),
        .cnt_i(tx_count_o), .cnt_nxt_i(tx_nxt), .irq_o(tx_irq_o)
    );

endmodule

// File: rtl/sfifo_irq_chk.sv
module sfifo_irq_chk #(
    parameter int CTL_W = 8,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             duplex_i,
    input logic             ctl_wr_rx_i,
    input logic             ctl_wr_tx_i,
    input logic [CTL_W-1:0] ctl_wdata_i,
    input logic [CTL_W-1:0] ctl_rx_o,
    input logic [CTL_W-1:0] ctl_tx_o,
    input logic             rx_push_i,
    input logic             rx_pop_i,
    input logic             tx_push_i,
    input logic             tx_pop_i,
    input logic             rx_irq_o,
    input logic             tx_irq_o,
    input logic             rx_full_o,
    input logic             rx_empty_o,
    input logic [CNT_W-1:0] rx_count_o,
    input logic             rx_ovr_o,
    input logic             tx_full_o,
    input logic             tx_empty_o,
    input logic [CNT_W-1:0] tx_count_o,
    input logic             tx_ovr_o
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_ctl_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({ctl_rx_o[7], ctl_rx_o[5:2], ctl_tx_o[7], ctl_tx_o[5:2]} == 10'd0));

    assert_rx_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctl_wr_rx_i && ctl_wdata_i[7]))
        |-> (rx_count_o == '0 && !rx_irq_o && !rx_ovr_o));

    assert_tx_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctl_wr_tx_i && ctl_wdata_i[7]))
        |-> (tx_count_o == '0 && !tx_irq_o && !tx_ovr_o));

    assert_rx_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rx_irq_o) |-> $past(rx_push_i || rx_pop_i));

    assert_tx_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tx_irq_o) |-> $past(tx_push_i || tx_pop_i));

    assert_rx_duplex_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && duplex_i && $past(duplex_i) && $past(rx_count_o) <= 2)
        |-> (rx_count_o <= 2));

    assert_rx_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rx_ovr_o) && !$past(ctl_wr_rx_i && ctl_wdata_i[7]))
        |-> rx_ovr_o);

    assert_tx_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(tx_ovr_o) && !$past(ctl_wr_tx_i && ctl_wdata_i[7]))
        |-> tx_ovr_o);

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rx_empty_o && rx_pop_i && !rx_push_i)) |-> rx_empty_o);

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full_o && rx_empty_o) && !(tx_full_o && tx_empty_o));

endmodule

bind sfifo_irq_ctrl sfifo_irq_chk #(.CTL_W(CTL_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/sfifo_irq_ctrl_tb_top.sv
module sfifo_irq_ctrl_tb_top;

    localparam time CLK_HALF = 2.5ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic duplex_i = 1'b0;
    logic ctl_wr_rx_i = 1'b0, ctl_wr_tx_i = 1'b0;
    logic [7:0] ctl_wdata_i = '0;
    logic [7:0] ctl_rx_o, ctl_tx_o;
    logic rx_push_i = 1'b0, rx_pop_i = 1'b0, tx_push_i = 1'b0, tx_pop_i = 1'b0;
    logic [7:0] rx_din_i = '0, tx_din_i = '0, rx_dout_o, tx_dout_o;
    logic rx_irq_o, tx_irq_o, rx_full_o, rx_empty_o, rx_ovr_o;
    logic tx_full_o, tx_empty_o, tx_ovr_o;
    logic [2:0] rx_count_o, tx_count_o;

    always #CLK_HALF clk = ~clk;

    sfifo_irq_ctrl dut_i (.*);

    int checks = 0;
    int errors = 0;

    // reference state, built from the requirements
    int rcnt = 0, tcnt = 0;
    bit rovr = 0, tovr = 0, rmode = 0, tmode = 0;
    logic [1:0] rcode = 0, tcode = 0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int thr_of(input bit is_rx, input logic [1:0] c, input bit d);
        logic [1:0] e;
        e = d ? {1'b0, c[0]} : c;
        if (e == 2'd0) return is_rx ? (d ? 2 : 4) : 0;
        return int'(e);
    endfunction

    function automatic void model(input bit is_rx, input bit clr, input bit push, input bit pop,
                                  input int cnt, input int lim, input int thr, input bit mode,
                                  output int ncnt, output bit pok, output bit uok, output bit irq);
        if (clr) begin
            ncnt = 0; pok = 0; uok = 0; irq = 0;
            return;
        end
        uok  = pop && cnt > 0;
        pok  = push && (cnt < lim || uok);
        ncnt = cnt + int'(pok) - int'(uok);
        if (is_rx) irq = (cnt < thr && ncnt == thr) || (mode && uok && ncnt > thr);
        else       irq = (cnt > thr && ncnt == thr) || (mode && pok && ncnt < thr);
    endfunction

    // driver + scoreboard for one cycle of stimulus
    task automatic step(input string tag,
                        input bit rwr, input logic [7:0] rwd, input bit twr, input logic [7:0] twd,
                        input bit rp, input logic [7:0] rd, input bit rpo,
                        input bit tp, input logic [7:0] td, input bit tpo);
        int rn, tn, rlim;
        bit rpk, ruk, rirq, tpk, tuk, tirq, rclr, tclr;
        logic [7:0] exp_d;
        @(negedge clk);
        ctl_wr_rx_i = rwr; ctl_wr_tx_i = twr; ctl_wdata_i = rwr ? rwd : twd;
        rx_push_i = rp; rx_din_i = rd; rx_pop_i = rpo;
        tx_push_i = tp; tx_din_i = td; tx_pop_i = tpo;
        rclr = rwr && rwd[7];
        tclr = twr && twd[7];
        rlim = duplex_i ? 2 : 4;
        #1;
        if (rpo && !rclr) begin
            exp_d = (rx_q.size() > 0) ? rx_q[0] : 8'h00;
            check(tag, "rx_dout", rx_dout_o, exp_d);
        end
        if (tpo && !tclr) begin
            exp_d = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
            check(tag, "tx_dout", tx_dout_o, exp_d);
        end
        model(1'b1, rclr, rp, rpo, rcnt, rlim, thr_of(1'b1, rcode, duplex_i), rmode, rn, rpk, ruk, rirq);
        model(1'b0, tclr, tp, tpo, tcnt, 4, thr_of(1'b0, tcode, duplex_i), tmode, tn, tpk, tuk, tirq);
        if (rclr) begin rx_q.delete(); rovr = 0; end
        else begin
            if (ruk) void'(rx_q.pop_front());
            if (rpk) rx_q.push_back(rd);
            if (rp && !rpk) rovr = 1;
        end
        if (tclr) begin tx_q.delete(); tovr = 0; end
        else begin
            if (tuk) void'(tx_q.pop_front());
            if (tpk) tx_q.push_back(td);
            if (tp && !tpk) tovr = 1;
        end
        if (rwr) begin rmode = rwd[6]; rcode = rwd[1:0]; end
        if (twr) begin tmode = twd[6]; tcode = twd[1:0]; end
        rcnt = rn; tcnt = tn;
        @(posedge clk); #1;
        check(tag, "rx_irq", rx_irq_o, rirq);
        check(tag, "tx_irq", tx_irq_o, tirq);
        check(tag, "rx_count", rx_count_o, rcnt);
        check(tag, "tx_count", tx_count_o, tcnt);
        check(tag, "rx_full", rx_full_o, rcnt >= rlim);
        check(tag, "rx_empty", rx_empty_o, rcnt == 0);
        check(tag, "tx_full", tx_full_o, tcnt >= 4);
        check(tag, "tx_empty", tx_empty_o, tcnt == 0);
        check(tag, "rx_ovr", rx_ovr_o, rovr);
        check(tag, "tx_ovr", tx_ovr_o, tovr);
        @(negedge clk);
        ctl_wr_rx_i = 0; ctl_wr_tx_i = 0; rx_push_i = 0; rx_pop_i = 0; tx_push_i = 0; tx_pop_i = 0;
    endtask

    task automatic rpush(input string tag, input logic [7:0] d); step(tag, 0, 0, 0, 0, 1, d, 0, 0, 0, 0); endtask
    task automatic rpop(input string tag);  step(tag, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); endtask
    task automatic tpush(input string tag, input logic [7:0] d); step(tag, 0, 0, 0, 0, 0, 0, 0, 1, d, 0); endtask
    task automatic tpop(input string tag);  step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); endtask
    task automatic rwr(input string tag, input logic [7:0] v); step(tag, 1, v, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic twr(input string tag, input logic [7:0] v); step(tag, 0, 0, 1, v, 0, 0, 0, 0, 0, 0); endtask
    task automatic idle(input string tag); step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "rx_count", rx_count_o, 0);
        check("R1", "tx_count", tx_count_o, 0);
        check("R1", "rx_empty", rx_empty_o, 1);
        check("R1", "tx_empty", tx_empty_o, 1);
        check("R1", "irqs", {rx_irq_o, tx_irq_o, rx_full_o, tx_full_o, rx_ovr_o, tx_ovr_o}, 0);
        check("R1", "ctl_rx", ctl_rx_o, 0);
        check("R1", "ctl_tx", ctl_tx_o, 0);

        // R2 / R11: code 0 = 4 bytes, one pulse on the 4th push, none while it sits there
        for (int i = 0; i < 4; i++) rpush("R2", 8'hA0 + 8'(i));
        idle("R11");
        // R9: overflow drops and sets sticky flag
        rpush("R9", 8'hEE);
        idle("R9");
        // R10: arrival order, then pop on empty
        for (int i = 0; i < 4; i++) rpop("R10");
        rpop("R10");
        check("R10", "rx_dout_empty", rx_dout_o, 0);
        // R8: flush with a simultaneous push
        rpush("R9", 8'h11);
        step("R8", 1, 8'h80, 0, 0, 1, 8'h22, 1, 0, 0, 0);

        // R3: transmit code 0 = empty
        tpush("R3", 8'h31); tpush("R3", 8'h32);
        tpop("R3"); tpop("R3");

        // R7 + R5: mode 1, code 2
        rwr("R7", 8'h42);
        check("R7", "ctl_rx_rb", ctl_rx_o, 8'h42);
        for (int i = 0; i < 4; i++) rpush("R5", 8'h50 + 8'(i));
        rpop("R5"); rpop("R5"); rpop("R5");

        // R6: mode 1, code 3 on transmit; R3 falling onto 3
        twr("R7", 8'h7F);
        check("R7", "ctl_tx_rb", ctl_tx_o, 8'h43);
        for (int i = 0; i < 5; i++) tpush("R6", 8'h60 + 8'(i));
        tpop("R3");
        twr("R8", 8'hC3);
        check("R7", "ctl_tx_flush_rb", ctl_tx_o, 8'h43);

        // R4: full duplex
        rwr("R8", 8'h80);
        @(negedge clk) duplex_i = 1'b1;
        rwr("R4", 8'h00);
        rpush("R4", 8'h71); rpush("R4", 8'h72); rpush("R9", 8'h73);
        rwr("R4", 8'h02);
        rpop("R4"); rpop("R4");
        rpush("R4", 8'h74); rpush("R4", 8'h75);
        twr("R4", 8'h02);
        tpush("R4", 8'h81); tpop("R4");
        twr("R4", 8'h03);
        tpush("R4", 8'h82); tpush("R4", 8'h83); tpop("R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule